// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is one DMA channel engine that keeps two buffer descriptors, A and B. Each descriptor holds a current address and an end word. The engine moves data for one descriptor while software refills the other. Each unit of work is a paired handshake. A peripheral raises a level request. The engine then issues one memory access at the current address. After memory acknowledges, the engine returns a one-cycle acknowledge to the peripheral and steps the address by the programmed transfer size.

When the active descriptor completes its final transfer, the engine marks that descriptor empty and turns to the other one. If the other one is not loaded, the engine raises an overflow condition and waits. A stop flag in the end word ends the whole sequence after that descriptor. A second flag marks a descriptor that holds a single transfer. Software configures the channel through six word-indexed registers. It learns which descriptor to refill from a status bit. An interrupt line stays high while the channel is enabled and any descriptor is empty.

Top module: `pp_dma_chan`

## Requirements
- R1: The register index selects the target. Index 0 is current-A and index 1 is end-A. Index 2 is current-B and index 3 is end-B. Index 4 is control and index 5 is status. A current register reads back the low 16 address bits, with the upper bits zero. An end register reads back its 16-bit address, bit 30 and bit 31.
- R2: Control bits 1:0 select the transfer size as 1, 2, 4 or 8 bytes (1 shifted left by the code). Bit 2 is the direction: 1 means device-to-memory, which drives `mem_we` high. Bit 3 enables the channel. Reading control returns bits 3:0.
- R3: Writing control with bit 7 set clears the channel. Both descriptors become empty, A becomes the active descriptor and the one to refill, and overflow and halt are cleared. Bits 3:0 of the same write are still stored.
- R4: A transfer starts when four conditions hold: the channel is enabled, it is not halted, the active descriptor is loaded and `dev_req` is high. The engine holds `mem_req` with a stable `mem_addr` equal to the current address until `mem_ack`. It pulses `dev_ack` for one cycle in the next cycle, and the current address then advances by the transfer size.
- R5: A transfer made at the end word's address is the last one for that descriptor. The descriptor then becomes empty and the other descriptor becomes active.
- R6: When bit 30 of the end word is set, the descriptor becomes empty after its first transfer, whatever its end address.
- R7: When bit 31 of the end word is set, the engine halts once that descriptor empties. It starts no more transfers, even if the other descriptor is loaded, until a clear.
- R8: Status bit 1 (overflow) sets when a descriptor empties while the other is unloaded, and no transfer starts while it is set. Writing either end register clears overflow.
- R9: The `irq` output and status bit 0 are high exactly when the channel is enabled and at least one descriptor is empty.
- R10: Status bit 2 tells which descriptor to refill next. It reads 0 (A) after a clear, 1 after an end-A write and 0 after an end-B write.
- R11: Writing 0 to control stops new transfers; a transfer already in progress completes. Enabling again resumes at the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on reg_addr) |
| dev_req | input | 1 | Peripheral transfer request (level) |
| dev_ack | output | 1 | Peripheral acknowledge, one cycle per transfer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (device-to-memory) |
| mem_addr | output | ADDR_W | Memory access address |
| mem_ack | input | 1 | Memory acknowledge |
| irq | output | 1 | Descriptor-free interrupt |

## Verification
The main sweep covers every combination of direction, transfer size and descriptor length from one to three transfers. Each run chains A into a stopping B. It separates stride errors, off-by-one end detection, wrong switch order and direction leaks. Single-descriptor runs, with B loaded late, exercise overflow and recovery. Runs with one flag set tell the single-transfer flag apart from the stop flag. A long descriptor cut off by a disable shows that the in-flight transfer completes and that the resume address is correct.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
   // register indices
   localparam logic [2:0] RI_CUR_A = 3'd0;
   localparam logic [2:0] RI_END_A = 3'd1;
   localparam logic [2:0] RI_CUR_B = 3'd2;
   localparam logic [2:0] RI_END_B = 3'd3;
   localparam logic [2:0] RI_CTRL  = 3'd4;
   localparam logic [2:0] RI_STAT  = 3'd5;

   // control bit positions
   localparam int unsigned CB_SIZE_LO = 0;
   localparam int unsigned CB_DIR     = 2;
   localparam int unsigned CB_EN      = 3;
   localparam int unsigned CB_CLR     = 7;

   typedef enum logic [1:0] {
      XF_IDLE = 2'd0,
      XF_MEM  = 2'd1,
      XF_DACK = 2'd2
   } xf_state_e;
endpackage

// File: rtl/pp_dma_bufset.sv
module pp_dma_bufset #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              cur_wr_i,
   input  logic [ADDR_W-1:0] cur_val_i,
   input  logic              end_wr_i,
   input  logic [ADDR_W-1:0] end_val_i,
   input  logic              end_last_i,
   input  logic              end_stop_i,
   input  logic              adv_i,
   input  logic [ADDR_W-1:0] step_i,
   input  logic              drain_i,
   output logic [ADDR_W-1:0] cur_o,
   output logic [ADDR_W-1:0] end_o,
   output logic              last_o,
   output logic              stop_o,
   output logic              loaded_o,
   output logic              hit_o
);
   logic [ADDR_W-1:0] cur_q, end_q;
   logic              last_q, stop_q, loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (cur_wr_i) begin
         cur_q <= cur_val_i;
      end else if (adv_i) begin
         cur_q <= cur_q + step_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q  <= '0;
         last_q <= 1'b0;
         stop_q <= 1'b0;
      end else if (end_wr_i) begin
         end_q  <= end_val_i;
         last_q <= end_last_i;
         stop_q <= end_stop_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded_q <= 1'b0;
      end else if (clr_i) begin
         loaded_q <= 1'b0;
      end else if (end_wr_i) begin
         loaded_q <= 1'b1;
      end else if (drain_i) begin
         loaded_q <= 1'b0;
      end
   end

   assign cur_o    = cur_q;
   assign end_o    = end_q;
   assign last_o   = last_q;
   assign stop_o   = stop_q;
   assign loaded_o = loaded_q;
   assign hit_o    = (cur_q == end_q) || last_q;
endmodule

// File: rtl/pp_dma_xfer.sv
module pp_dma_xfer
   import pp_dma_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              dir_i,
   input  logic              mem_ack_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              dev_ack_o,
   output logic              done_o,
   output logic              busy_o
);
   xf_state_e         st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic              dir_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         XF_IDLE: if (start_i)   st_d = XF_MEM;
         XF_MEM:  if (mem_ack_i) st_d = XF_DACK;
         XF_DACK:                st_d = XF_IDLE;
         default:                st_d = XF_IDLE;
      endcase
      if (abort_i) st_d = XF_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= XF_IDLE;
         addr_q <= '0;
         dir_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == XF_IDLE && start_i) begin
            addr_q <= addr_i;
            dir_q  <= dir_i;
         end
      end
   end

   assign mem_req_o  = (st_q == XF_MEM);
   assign mem_we_o   = dir_q;
   assign mem_addr_o = addr_q;
   assign dev_ack_o  = (st_q == XF_DACK);
   assign done_o     = (st_q == XF_DACK) && !abort_i;
   assign busy_o     = (st_q != XF_IDLE);
endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       done_i,
   input  logic       hit_i,
   input  logic       stop_i,
   input  logic [1:0] loaded_i,
   input  logic [1:0] end_wr_i,
   output logic       act_o,
   output logic       fill_o,
   output logic       ovf_o,
   output logic       halt_o,
   output logic [1:0] drain_o
);
   logic act_q, fill_q, ovf_q, halt_q;
   logic empty_ev, other_ready;

   assign empty_ev    = done_i && hit_i;
   assign other_ready = loaded_i[!act_q] || end_wr_i[!act_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         fill_q <= 1'b0;
         ovf_q  <= 1'b0;
         halt_q <= 1'b0;
      end else if (clr_i) begin
         act_q  <= 1'b0;
         fill_q <= 1'b0;
         ovf_q  <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         if (end_wr_i[0]) fill_q <= 1'b1;
         if (end_wr_i[1]) fill_q <= 1'b0;
         if (|end_wr_i)   ovf_q  <= 1'b0;
         if (empty_ev) begin
            if (stop_i) begin
               halt_q <= 1'b1;
            end else begin
               act_q <= !act_q;
               ovf_q <= !other_ready;
            end
         end
      end
   end

   assign drain_o[0] = empty_ev && !act_q;
   assign drain_o[1] = empty_ev &&  act_q;
   assign act_o      = act_q;
   assign fill_o     = fill_q;
   assign ovf_o      = ovf_q;
   assign halt_o     = halt_q;
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
   import pp_dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              dev_req,
   output logic              dev_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic              irq
);
   localparam int STOP_BIT = DATA_W - 1;
   localparam int LAST_BIT = DATA_W - 2;
   localparam int PAD_W    = DATA_W - 2 - ADDR_W;

   if (ADDR_W < 8) begin : g_aw_chk
      $error("pp_dma_chan: ADDR_W must be at least 8");
   end
   if (PAD_W < 1) begin : g_dw_chk
      $error("pp_dma_chan: DATA_W must exceed ADDR_W + 2");
   end

   logic       ctl_en, ctl_dir;
   logic [1:0] ctl_size;
   logic       ctrl_wr, clr;
   logic [ADDR_W-1:0] step;

   logic [1:0][ADDR_W-1:0] cur_q, end_q;
   logic [1:0] last_q, stop_q, loaded, hit, drain, cur_wr, end_wr, adv;

   logic act, fill, ovf, halted;
   logic xf_done, xf_busy, xf_start, run;
   logic unused_wbits;

   assign unused_wbits = ^reg_wdata[LAST_BIT-1:ADDR_W];

   assign ctrl_wr = reg_wr && (reg_addr == RI_CTRL);
   assign clr     = ctrl_wr && reg_wdata[CB_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en   <= 1'b0;
         ctl_dir  <= 1'b0;
         ctl_size <= 2'd0;
      end else if (ctrl_wr) begin
         ctl_en   <= reg_wdata[CB_EN];
         ctl_dir  <= reg_wdata[CB_DIR];
         ctl_size <= reg_wdata[CB_SIZE_LO+1:CB_SIZE_LO];
      end
   end

   assign step = ADDR_W'(1) << ctl_size;

   for (genvar b = 0; b < 2; b++) begin : g_buf
      localparam logic [2:0] CUR_IDX = 3'(2 * b);
      localparam logic [2:0] END_IDX = 3'(2 * b + 1);

      assign cur_wr[b] = reg_wr && (reg_addr == CUR_IDX);
      assign end_wr[b] = reg_wr && (reg_addr == END_IDX);
      assign adv[b]    = xf_done && (act == 1'(b));

      pp_dma_bufset #(.ADDR_W(ADDR_W)) u_set (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr_i     (clr),
         .cur_wr_i  (cur_wr[b]),
         .cur_val_i (reg_wdata[ADDR_W-1:0]),
         .end_wr_i  (end_wr[b]),
         .end_val_i (reg_wdata[ADDR_W-1:0]),
         .end_last_i(reg_wdata[LAST_BIT]),
         .end_stop_i(reg_wdata[STOP_BIT]),
         .adv_i     (adv[b]),
         .step_i    (step),
         .drain_i   (drain[b]),
         .cur_o     (cur_q[b]),
         .end_o     (end_q[b]),
         .last_o    (last_q[b]),
         .stop_o    (stop_q[b]),
         .loaded_o  (loaded[b]),
         .hit_o     (hit[b])
      );
   end

   pp_dma_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .done_i  (xf_done),
      .hit_i   (hit[act]),
      .stop_i  (stop_q[act]),
      .loaded_i(loaded),
      .end_wr_i(end_wr),
      .act_o   (act),
      .fill_o  (fill),
      .ovf_o   (ovf),
      .halt_o  (halted),
      .drain_o (drain)
   );

   assign run      = ctl_en && !halted && loaded[act];
   assign xf_start = run && dev_req && !xf_busy;

   pp_dma_xfer #(.ADDR_W(ADDR_W)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_i   (clr),
      .start_i   (xf_start),
      .addr_i    (cur_q[act]),
      .dir_i     (ctl_dir),
      .mem_ack_i (mem_ack),
      .mem_req_o (mem_req),
      .mem_we_o  (mem_we),
      .mem_addr_o(mem_addr),
      .dev_ack_o (dev_ack),
      .done_o    (xf_done),
      .busy_o    (xf_busy)
   );

   assign irq = ctl_en && !(&loaded);

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RI_CUR_A: reg_rdata = DATA_W'(cur_q[0]);
         RI_END_A: reg_rdata = {stop_q[0], last_q[0], {PAD_W{1'b0}}, end_q[0]};
         RI_CUR_B: reg_rdata = DATA_W'(cur_q[1]);
         RI_END_B: reg_rdata = {stop_q[1], last_q[1], {PAD_W{1'b0}}, end_q[1]};
         RI_CTRL:  reg_rdata = DATA_W'({ctl_en, ctl_dir, ctl_size});
         RI_STAT:  reg_rdata = DATA_W'({fill, ovf, irq});
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pp_dma_chan_chk.sv
module pp_dma_chan_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              dev_ack,
   input logic              irq,
   input logic              en_q,
   input logic              ovf_q,
   input logic              halted_q
);
   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   // R4
   ack_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> $past(mem_req && mem_ack));
   // R4
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> !dev_ack);
   // R7
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |=> !$rose(mem_req));
   // R8
   ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> !$rose(mem_req));
   // R11
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !$rose(mem_req));
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> en_q);
endmodule

bind pp_dma_chan pp_dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mem_req (mem_req),
   .mem_ack (mem_ack),
   .mem_addr(mem_addr),
   .dev_ack (dev_ack),
   .irq     (irq),
   .en_q    (ctl_en),
   .ovf_q   (ovf),
   .halted_q(halted)
);

// File: tb/pp_dma_chan_tb_top.sv
`timescale 1ns/1ps
module pp_dma_chan_tb_top;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          dev_req = 1'b0;
   logic          dev_ack, mem_req, mem_we, mem_ack, irq;
   logic [AW-1:0] mem_addr;
   logic          ack_en = 1'b1;

   always #2.5 clk = ~clk;
   assign mem_ack = mem_req && ack_en;

   pp_dma_chan #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
      .dev_ack(dev_ack), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq));

   int checks = 0;
   int fails = 0;
   logic [AW-1:0] log_a [0:127];
   logic          log_we [0:127];
   int            log_n = 0;
   logic          log_clr = 1'b0;

   always @(posedge clk) begin
      if (log_clr) begin
         log_n <= 0;
      end else if (rst_n && mem_req && mem_ack) begin
         if (log_n < 128) begin
            log_a[log_n]  <= mem_addr;
            log_we[log_n] <= mem_we;
         end
         log_n <= log_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic clear_log();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int n1, n2, step;
      logic [15:0] ea, eb;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      rd(3'd5, v); chk("R9 reset status", v, 32'h0);
      rd(3'd4, v); chk("R2 reset ctrl", v, 32'h0);
      chk("R9 reset irq", {31'b0, irq}, 32'h0);
      chk("R4 reset mem_req", {31'b0, mem_req}, 32'h0);

      // R1 register map readback
      wr(3'd0, 32'hABCD_1234); rd(3'd0, v); chk("R1 curA", v, 32'h0000_1234);
      wr(3'd1, 32'hC000_5678); rd(3'd1, v); chk("R1 endA", v, 32'hC000_5678);
      wr(3'd2, 32'h0000_9ABC); rd(3'd2, v); chk("R1 curB", v, 32'h0000_9ABC);
      wr(3'd3, 32'h4000_0102); rd(3'd3, v); chk("R1 endB", v, 32'h4000_0102);
      rd(3'd5, v); chk("R10 sel after endB", v, 32'h0);
      wr(3'd4, 32'h8F); rd(3'd4, v); chk("R3 ctrl kept with clear", v, 32'h0F);
      rd(3'd5, v); chk("R3 status after clear+enable", v, 32'h1);
      wr(3'd4, 32'h80); rd(3'd5, v); chk("R3 status after clear", v, 32'h0);

      // main sweep: direction x size x length
      for (int d = 0; d < 2; d++) begin
         for (int s = 0; s < 4; s++) begin
            for (int n = 1; n <= 3; n++) begin
               step = 1 << s;
               ea = 16'(32'h100 + (n - 1) * step);
               eb = 16'(32'h400 + (n - 1) * step);
               dev_req = 1'b0;
               wr(3'd4, 32'h80);
               clear_log();
               wr(3'd4, 32'(8 + d * 4 + s));
               rd(3'd5, v); chk("R9 both empty", v, 32'h1);
               wr(3'd0, 32'h100);
               wr(3'd1, {16'h0, ea});
               rd(3'd5, v); chk("R10 sel B after endA", v, 32'h5);
               wr(3'd2, 32'h400);
               wr(3'd3, {16'h8000, eb});
               rd(3'd5, v); chk("R9 both loaded", v, 32'h0);
               dev_req = 1'b1;
               repeat (40) @(negedge clk);
               dev_req = 1'b0;
               chk("R5 count", 32'(log_n), 32'(2 * n));
               for (int k = 0; k < 2 * n && k < 128; k++) begin
                  if (k < n) chk("R4 addr A", {16'h0, log_a[k]}, 32'h100 + k * step);
                  else       chk("R5 addr B", {16'h0, log_a[k]}, 32'h400 + (k - n) * step);
                  chk("R2 direction", {31'b0, log_we[k]}, 32'(d));
               end
               rd(3'd0, v); chk("R2 curA stride", v, 32'h100 + n * step);
               rd(3'd2, v); chk("R2 curB stride", v, 32'h400 + n * step);
               rd(3'd5, v); chk("R7 status after stop", v, 32'h1);
            end
         end
      end

      // R8 overflow and recovery
      wr(3'd4, 32'h80); clear_log(); wr(3'd4, 32'h09);
      wr(3'd0, 32'h20); wr(3'd1, 32'h24);
      dev_req = 1'b1;
      repeat (30) @(negedge clk);
      chk("R8 count A", 32'(log_n), 32'd3);
      chk("R8 last addr A", {16'h0, log_a[2]}, 32'h24);
      rd(3'd5, v); chk("R8 overflow status", v, 32'h7);
      wr(3'd2, 32'h80); wr(3'd3, 32'h80);
      rd(3'd5, v); chk("R8 overflow cleared", v, 32'h1);
      repeat (20) @(negedge clk);
      chk("R8 resume count", 32'(log_n), 32'd4);
      chk("R8 resume addr", {16'h0, log_a[3]}, 32'h80);
      rd(3'd5, v); chk("R8 overflow again", v, 32'h3);
      dev_req = 1'b0;

      // R6 single-transfer flag
      wr(3'd4, 32'h80); clear_log(); wr(3'd4, 32'h09);
      wr(3'd0, 32'h10); wr(3'd1, 32'h4000_0050);
      wr(3'd2, 32'h200); wr(3'd3, 32'h8000_0202);
      dev_req = 1'b1;
      repeat (30) @(negedge clk);
      dev_req = 1'b0;
      chk("R6 count", 32'(log_n), 32'd3);
      chk("R6 addr0", {16'h0, log_a[0]}, 32'h10);
      chk("R6 addr1", {16'h0, log_a[1]}, 32'h200);
      chk("R6 addr2", {16'h0, log_a[2]}, 32'h202);
      rd(3'd0, v); chk("R6 curA", v, 32'h12);

      // R7 stop with other descriptor loaded
      wr(3'd4, 32'h80); clear_log(); wr(3'd4, 32'h09);
      wr(3'd0, 32'h30); wr(3'd1, 32'h8000_0030);
      wr(3'd2, 32'h300); wr(3'd3, 32'h302);
      dev_req = 1'b1;
      repeat (30) @(negedge clk);
      dev_req = 1'b0;
      chk("R7 count", 32'(log_n), 32'd1);
      chk("R7 addr", {16'h0, log_a[0]}, 32'h30);
      rd(3'd2, v); chk("R7 curB untouched", v, 32'h300);
      rd(3'd5, v); chk("R7 status", v, 32'h1);
      wr(3'd4, 32'h80);
      rd(3'd5, v); chk("R3 clear after halt", v, 32'h0);
      chk("R9 irq off", {31'b0, irq}, 32'h0);

      // R11 disable mid-stream, then resume
      clear_log(); wr(3'd4, 32'h09);
      wr(3'd0, 32'h0); wr(3'd1, 32'h7E);
      dev_req = 1'b1;
      repeat (10) @(negedge clk);
      wr(3'd4, 32'h0);
      n1 = log_n;
      repeat (20) @(negedge clk);
      n2 = log_n;
      chk("R11 at most one more", 32'((n2 - n1) <= 1), 32'd1);
      chk("R11 some progress", 32'(n2 > 0), 32'd1);
      repeat (10) @(negedge clk);
      chk("R11 stopped", 32'(log_n), 32'(n2));
      chk("R11 irq low", {31'b0, irq}, 32'h0);
      rd(3'd5, v); chk("R11 status", v, 32'h4);
      rd(3'd0, v); chk("R11 curA", v, 32'(2 * n2));
      wr(3'd4, 32'h09);
      repeat (10) @(negedge clk);
      dev_req = 1'b0;
      chk("R11 resumed", 32'(log_n > n2), 32'd1);
      if (n2 < 128) chk("R11 resume addr", {16'h0, log_a[n2]}, 32'(2 * n2));

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule